// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside an 8-bit processor core and controls what happens at each instruction boundary. When the core signals that an instruction has finished, the sequencer decides between three paths. It can hand straight back to instruction fetch. It can run an interrupt entry, which saves the program counter, index register, accumulator and condition codes on a byte-wide stack in memory, masks further interrupts and jumps through a vector. When the finished instruction was a return-from-interrupt, it instead runs a return that reloads the saved context.

The sequencer holds the four architectural registers and the stack pointer itself. The core updates the registers through a load port while the sequencer is idle. Stack and vector traffic share one memory port whose reads return data one cycle after the request. The interrupt mask is a bit inside the condition codes. Because the condition codes come back from the stack on return, the mask takes its saved value again without any explicit unmask step.

Top module: `irq_seq`

## Requirements
- R1: After reset, `pc` equals PC_INIT (default 0), `sp` equals SP_INIT (default 0x00FF), `cc` has only the mask bit (bit I_BIT, default 3) set, and `busy` is low.
- R2: When `instr_done` is high while idle, `iret_req` is low, and either `irq_pending` is low or the mask bit of the condition codes is set, `fetch_go` is high in that same cycle, nothing is written to memory, and `busy` stays low.
- R3: An interrupt entry writes five bytes to memory in consecutive cycles: PC low byte, PC high byte, X, A, then CC. Each byte goes to the current `sp`, and `sp` decrements after each write, so it ends five below its start.
- R4: After the five writes, the mask bit in `cc` is set. `pc` is loaded with its high byte from `vec_addr` and its low byte from `vec_addr`+1. The CC byte on the stack holds the value from before the mask was set.
- R5: `irq_ack` is a single-cycle pulse, issued once per entry in the final vector-load cycle, and `fetch_go` is high in that same cycle.
- R6: From the boundary cycle that starts an entry, `busy` is high for exactly 8 cycles.
- R7: A boundary with `iret_req` high reads CC, A, X, PC high and PC low, in that order. Before each read, `sp` is incremented and the read uses the new value. Afterwards all four registers hold their stacked values, so the mask bit takes its saved value, and `sp` is back to where it was before the matching entry. This takes 6 busy cycles.
- R8: At the end of a return, if `irq_pending` is high and the restored mask bit is clear, a new entry begins at once with no `fetch_go` (14 busy cycles in total). Otherwise `fetch_go` is pulsed and the block goes idle.
- R9: `core_wr` loads `core_pc`, `core_x`, `core_a` and `core_cc` into the registers only while idle. While `busy` is high it has no effect. A boundary decision uses the condition codes written in the same cycle.
- R10: `mem_we` and `mem_re` are never high together. Read data is taken from `mem_rdata` in the cycle after `mem_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_done | input | 1 | Instruction boundary strobe from the core |
| iret_req | input | 1 | The finishing instruction is a return-from-interrupt |
| irq_pending | input | 1 | An interrupt request is waiting |
| vec_addr | input | AW | Address of the vector high byte |
| core_wr | input | 1 | Load the registers from the core while idle |
| core_pc | input | 2*DW | Program counter value from the core |
| core_x | input | DW | Index register value from the core |
| core_a | input | DW | Accumulator value from the core |
| core_cc | input | DW | Condition code value from the core |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack or vector read strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Byte being pushed |
| mem_rdata | input | DW | Read data, one cycle after `mem_re` |
| pc | output | 2*DW | Program counter |
| x | output | DW | Index register |
| a | output | DW | Accumulator |
| cc | output | DW | Condition codes including the mask bit |
| sp | output | AW | Stack pointer |
| busy | output | 1 | Entry or return sequence in progress |
| fetch_go | output | 1 | Fetching may resume at `pc` from the next cycle |
| irq_ack | output | 1 | Entry acknowledge to the interrupt source |

## Verification
The assertions assume that memory returns read data exactly one cycle after a read strobe. They also assume that `instr_done` is raised only while the block is idle and that the surrounding logic leaves `irq_pending` high until the acknowledge pulse. The bench models the memory as a one-cycle synchronous byte array. It raises `instr_done` only after waiting for `busy` to fall, and it changes `irq_pending` only between sequences. It also writes the saved condition codes straight into its memory model to create a return with the mask bit saved as set.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [1:0] {
      ST_RUN,
      ST_PUSH,
      ST_VEC,
      ST_POP
   } seq_state_e;

   typedef enum logic [1:0] {
      SP_HOLD,
      SP_DEC,
      SP_INC
   } sp_op_e;

   typedef struct packed {
      logic core_ld;
      logic ld_pch;
      logic ld_pcl;
      logic ld_x;
      logic ld_a;
      logic ld_cc;
      logic set_mask;
   } rf_ctl_t;

   localparam int unsigned PUSH_BYTES = 5;
   localparam int unsigned VEC_STEPS  = 3;
   localparam int unsigned POP_STEPS  = 6;

endpackage

// File: rtl/irq_seq_sp.sv
module irq_seq_sp
   import irq_seq_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned WRAP_BITS = 8,
   parameter int unsigned SP_INIT   = 'hFF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  sp_op_e        sp_op,
   output logic [AW-1:0] sp,
   output logic [AW-1:0] sp_plus1
);

   logic [AW-1:0] sp_q;
   logic [AW-1:0] sp_dec;
   logic [AW-1:0] sp_inc;

   generate
      if (WRAP_BITS >= AW) begin : g_flat
         assign sp_dec = sp_q - AW'(1);
         assign sp_inc = sp_q + AW'(1);
      end else begin : g_window
         assign sp_dec = {sp_q[AW-1:WRAP_BITS], sp_q[WRAP_BITS-1:0] - WRAP_BITS'(1)};
         assign sp_inc = {sp_q[AW-1:WRAP_BITS], sp_q[WRAP_BITS-1:0] + WRAP_BITS'(1)};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= AW'(SP_INIT);
      end else begin
         case (sp_op)
            SP_DEC:  sp_q <= sp_dec;
            SP_INC:  sp_q <= sp_inc;
            default: sp_q <= sp_q;
         endcase
      end
   end

   assign sp       = sp_q;
   assign sp_plus1 = sp_inc;

endmodule

// File: rtl/irq_seq_regs.sv
module irq_seq_regs
   import irq_seq_pkg::*;
#(
   parameter int unsigned DW      = 8,
   parameter int unsigned I_BIT   = 3,
   parameter int unsigned PC_INIT = 0,
   localparam int unsigned PCW    = 2 * DW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  rf_ctl_t        ctl,
   input  logic [DW-1:0]  rdata,
   input  logic [PCW-1:0] core_pc,
   input  logic [DW-1:0]  core_x,
   input  logic [DW-1:0]  core_a,
   input  logic [DW-1:0]  core_cc,
   output logic [PCW-1:0] pc,
   output logic [DW-1:0]  x,
   output logic [DW-1:0]  a,
   output logic [DW-1:0]  cc
);

   localparam logic [DW-1:0] CC_RESET = DW'(1) << I_BIT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc <= PCW'(PC_INIT);
         x  <= '0;
         a  <= '0;
         cc <= CC_RESET;
      end else if (ctl.core_ld) begin
         pc <= core_pc;
         x  <= core_x;
         a  <= core_a;
         cc <= core_cc;
      end else begin
         if (ctl.ld_pch)   pc[PCW-1:DW] <= rdata;
         if (ctl.ld_pcl)   pc[DW-1:0]   <= rdata;
         if (ctl.ld_x)     x            <= rdata;
         if (ctl.ld_a)     a            <= rdata;
         if (ctl.ld_cc)    cc           <= rdata;
         if (ctl.set_mask) cc[I_BIT]    <= 1'b1;
      end
   end

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
   import irq_seq_pkg::*;
#(
   parameter int unsigned AW     = 16,
   parameter int unsigned DW     = 8,
   parameter int unsigned I_BIT  = 3,
   localparam int unsigned PCW   = 2 * DW,
   localparam int unsigned STEPW = $clog2(POP_STEPS)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           instr_done,
   input  logic           iret_req,
   input  logic           irq_pending,
   input  logic           core_wr,
   input  logic [DW-1:0]  core_cc,
   input  logic [AW-1:0]  vec_addr,
   input  logic [PCW-1:0] pc,
   input  logic [DW-1:0]  x,
   input  logic [DW-1:0]  a,
   input  logic [DW-1:0]  cc,
   input  logic [AW-1:0]  sp,
   input  logic [AW-1:0]  sp_plus1,
   output sp_op_e         sp_op,
   output rf_ctl_t        rf_ctl,
   output logic           mem_we,
   output logic           mem_re,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   output logic           busy,
   output logic           fetch_go,
   output logic           irq_ack
);

   localparam logic [STEPW-1:0] LAST_PUSH = STEPW'(PUSH_BYTES - 1);
   localparam logic [STEPW-1:0] LAST_VEC  = STEPW'(VEC_STEPS - 1);
   localparam logic [STEPW-1:0] LAST_POP  = STEPW'(POP_STEPS - 1);

   seq_state_e       state_q, state_d;
   logic [STEPW-1:0] step_q, step_d;
   logic [DW-1:0]    cc_eff;
   logic             take_run;
   logic             take_ret;

   assign cc_eff   = core_wr ? core_cc : cc;
   assign take_run = irq_pending && !cc_eff[I_BIT];
   assign take_ret = irq_pending && !cc[I_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         step_q  <= '0;
      end else begin
         state_q <= state_d;
         step_q  <= step_d;
      end
   end

   always_comb begin
      state_d   = state_q;
      step_d    = step_q;
      sp_op     = SP_HOLD;
      rf_ctl    = '0;
      mem_we    = 1'b0;
      mem_re    = 1'b0;
      mem_addr  = sp;
      mem_wdata = cc;
      fetch_go  = 1'b0;
      irq_ack   = 1'b0;
      case (state_q)
         ST_RUN: begin
            rf_ctl.core_ld = core_wr;
            if (instr_done) begin
               step_d = '0;
               if (iret_req) begin
                  state_d = ST_POP;
               end else if (take_run) begin
                  state_d = ST_PUSH;
               end else begin
                  fetch_go = 1'b1;
               end
            end
         end
         ST_PUSH: begin
            mem_we   = 1'b1;
            mem_addr = sp;
            sp_op    = SP_DEC;
            case (step_q)
               STEPW'(0): mem_wdata = pc[DW-1:0];
               STEPW'(1): mem_wdata = pc[PCW-1:DW];
               STEPW'(2): mem_wdata = x;
               STEPW'(3): mem_wdata = a;
               default:   mem_wdata = cc;
            endcase
            if (step_q == LAST_PUSH) begin
               rf_ctl.set_mask = 1'b1;
               state_d         = ST_VEC;
               step_d          = '0;
            end else begin
               step_d = step_q + STEPW'(1);
            end
         end
         ST_VEC: begin
            mem_re   = (step_q != LAST_VEC);
            mem_addr = (step_q == '0) ? vec_addr : vec_addr + AW'(1);
            if (step_q == STEPW'(1)) rf_ctl.ld_pch = 1'b1;
            if (step_q == LAST_VEC) begin
               rf_ctl.ld_pcl = 1'b1;
               irq_ack       = 1'b1;
               fetch_go      = 1'b1;
               state_d       = ST_RUN;
               step_d        = '0;
            end else begin
               step_d = step_q + STEPW'(1);
            end
         end
         ST_POP: begin
            mem_addr = sp_plus1;
            if (step_q != LAST_POP) begin
               mem_re = 1'b1;
               sp_op  = SP_INC;
            end
            case (step_q)
               STEPW'(1): rf_ctl.ld_cc  = 1'b1;
               STEPW'(2): rf_ctl.ld_a   = 1'b1;
               STEPW'(3): rf_ctl.ld_x   = 1'b1;
               STEPW'(4): rf_ctl.ld_pch = 1'b1;
               STEPW'(5): rf_ctl.ld_pcl = 1'b1;
               default: ;
            endcase
            if (step_q == LAST_POP) begin
               step_d = '0;
               if (take_ret) begin
                  state_d = ST_PUSH;
               end else begin
                  fetch_go = 1'b1;
                  state_d  = ST_RUN;
               end
            end else begin
               step_d = step_q + STEPW'(1);
            end
         end
         default: begin
            state_d = ST_RUN;
            step_d  = '0;
         end
      endcase
   end

   assign busy = (state_q != ST_RUN);

endmodule

// File: rtl/irq_seq.sv
module irq_seq
   import irq_seq_pkg::*;
#(
   parameter int unsigned AW           = 16,
   parameter int unsigned DW           = 8,
   parameter int unsigned I_BIT        = 3,
   parameter int unsigned PC_INIT      = 0,
   parameter int unsigned SP_INIT      = 'hFF,
   parameter int unsigned SP_WRAP_BITS = 8,
   localparam int unsigned PCW         = 2 * DW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           instr_done,
   input  logic           iret_req,
   input  logic           irq_pending,
   input  logic [AW-1:0]  vec_addr,
   input  logic           core_wr,
   input  logic [PCW-1:0] core_pc,
   input  logic [DW-1:0]  core_x,
   input  logic [DW-1:0]  core_a,
   input  logic [DW-1:0]  core_cc,
   output logic           mem_we,
   output logic           mem_re,
   output logic [AW-1:0]  mem_addr,
   output logic [DW-1:0]  mem_wdata,
   input  logic [DW-1:0]  mem_rdata,
   output logic [PCW-1:0] pc,
   output logic [DW-1:0]  x,
   output logic [DW-1:0]  a,
   output logic [DW-1:0]  cc,
   output logic [AW-1:0]  sp,
   output logic           busy,
   output logic           fetch_go,
   output logic           irq_ack
);

   generate
      if (I_BIT >= DW) begin : g_bad_mask_bit
         $error("irq_seq: mask bit index outside the condition code byte");
      end
      if (SP_WRAP_BITS < 1 || SP_WRAP_BITS > AW) begin : g_bad_wrap
         $error("irq_seq: stack window width out of range");
      end
      if (AW < 2) begin : g_bad_aw
         $error("irq_seq: address width too small");
      end
   endgenerate

   sp_op_e        sp_op;
   rf_ctl_t       rf_ctl;
   logic [AW-1:0] sp_plus1;

   irq_seq_sp #(
      .AW        (AW),
      .WRAP_BITS (SP_WRAP_BITS),
      .SP_INIT   (SP_INIT)
   ) u_sp (
      .clk      (clk),
      .rst_n    (rst_n),
      .sp_op    (sp_op),
      .sp       (sp),
      .sp_plus1 (sp_plus1)
   );

   irq_seq_regs #(
      .DW      (DW),
      .I_BIT   (I_BIT),
      .PC_INIT (PC_INIT)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctl     (rf_ctl),
      .rdata   (mem_rdata),
      .core_pc (core_pc),
      .core_x  (core_x),
      .core_a  (core_a),
      .core_cc (core_cc),
      .pc      (pc),
      .x       (x),
      .a       (a),
      .cc      (cc)
   );

   irq_seq_ctrl #(
      .AW    (AW),
      .DW    (DW),
      .I_BIT (I_BIT)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_done  (instr_done),
      .iret_req    (iret_req),
      .irq_pending (irq_pending),
      .core_wr     (core_wr),
      .core_cc     (core_cc),
      .vec_addr    (vec_addr),
      .pc          (pc),
      .x           (x),
      .a           (a),
      .cc          (cc),
      .sp          (sp),
      .sp_plus1    (sp_plus1),
      .sp_op       (sp_op),
      .rf_ctl      (rf_ctl),
      .mem_we      (mem_we),
      .mem_re      (mem_re),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .busy        (busy),
      .fetch_go    (fetch_go),
      .irq_ack     (irq_ack)
   );

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
   parameter int unsigned AW           = 16,
   parameter int unsigned DW           = 8,
   parameter int unsigned I_BIT        = 3,
   parameter int unsigned SP_WRAP_BITS = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          instr_done,
   input logic          iret_req,
   input logic          core_wr,
   input logic          mem_we,
   input logic          mem_re,
   input logic [DW-1:0] cc,
   input logic [AW-1:0] sp,
   input logic          busy,
   input logic          fetch_go,
   input logic          irq_ack
);

   localparam int unsigned WB = (SP_WRAP_BITS > AW) ? AW : SP_WRAP_BITS;

   // R2: a masked boundary never starts stack writes
   a_r2_masked_no_push: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && instr_done && !iret_req && !core_wr && cc[I_BIT]) |=> !mem_we);

   // R3: every push leaves the pointer one lower
   a_r3_push_post_dec: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (sp[WB-1:0] == $past(sp[WB-1:0]) - WB'(1)));

   // R4: after the acknowledge the mask bit is set
   a_r4_ack_masks: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> cc[I_BIT]);

   // R5: acknowledge is a single pulse coinciding with fetch release
   a_r5_ack_with_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> fetch_go);
   a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq_ack);

   // R8: after fetch release the sequencer is idle
   a_r8_fetch_idle: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_go |=> !busy);

   // R10: the memory port never reads and writes together
   a_r10_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

endmodule

bind irq_seq irq_seq_chk #(
   .AW           (AW),
   .DW           (DW),
   .I_BIT        (I_BIT),
   .SP_WRAP_BITS (SP_WRAP_BITS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .instr_done (instr_done),
   .iret_req   (iret_req),
   .core_wr    (core_wr),
   .mem_we     (mem_we),
   .mem_re     (mem_re),
   .cc         (cc),
   .sp         (sp),
   .busy       (busy),
   .fetch_go   (fetch_go),
   .irq_ack    (irq_ack)
);

// File: tb/irq_seq_bench.sv
`timescale 1ns/1ps
module irq_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_done = 1'b0;
   logic        iret_req = 1'b0;
   logic        irq_pending = 1'b0;
   logic [15:0] vec_addr = 16'h0040;
   logic        core_wr = 1'b0;
   logic [15:0] core_pc = '0;
   logic [7:0]  core_x = '0;
   logic [7:0]  core_a = '0;
   logic [7:0]  core_cc = '0;
   logic        mem_we, mem_re;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic [15:0] pc;
   logic [7:0]  x, a, cc;
   logic [15:0] sp;
   logic        busy, fetch_go, irq_ack;

   logic [7:0]  mem [0:255];
   int          checks = 0;
   int          errors = 0;
   int          ack_cnt = 0;
   int          ack_bad = 0;
   int          wr_cnt = 0;

   always #2 clk = ~clk;

   irq_seq u_irq_seq (
      .clk (clk), .rst_n (rst_n), .instr_done (instr_done), .iret_req (iret_req),
      .irq_pending (irq_pending), .vec_addr (vec_addr), .core_wr (core_wr),
      .core_pc (core_pc), .core_x (core_x), .core_a (core_a), .core_cc (core_cc),
      .mem_we (mem_we), .mem_re (mem_re), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata), .pc (pc), .x (x), .a (a), .cc (cc), .sp (sp),
      .busy (busy), .fetch_go (fetch_go), .irq_ack (irq_ack)
   );

   always @(posedge clk) begin
      if (mem_we) begin
         mem[mem_addr[7:0]] <= mem_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
      if (irq_ack) ack_cnt <= ack_cnt + 1;
      if (irq_ack && !fetch_go) ack_bad <= ack_bad + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Raise a boundary, return fetch_go seen in that cycle and busy cycles after it.
   task automatic boundary(input logic ret, output logic fg, output int nbusy);
      @(negedge clk);
      instr_done = 1'b1;
      iret_req   = ret;
      #1 fg = fetch_go;
      @(negedge clk);
      instr_done = 1'b0;
      iret_req   = 1'b0;
      nbusy = 0;
      while (busy && nbusy < 100) begin
         nbusy++;
         @(negedge clk);
      end
   endtask

   task automatic core_load(input logic [15:0] p, input logic [7:0] xv, av, cv);
      @(negedge clk);
      core_wr = 1'b1; core_pc = p; core_x = xv; core_a = av; core_cc = cv;
      @(negedge clk);
      core_wr = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 pc", 32'(pc), 32'h0000);
      chk("R1 sp", 32'(sp), 32'h00FF);
      chk("R1 cc", 32'(cc), 32'h08);
      chk("R1 busy", 32'(busy), 32'h0);
   endtask

   task automatic t_masked;
      logic fg; int nb; int w0;
      w0 = wr_cnt;
      irq_pending = 1'b1;
      boundary(1'b0, fg, nb);
      chk("R2 fetch_go masked", 32'(fg), 32'h1);
      chk("R2 busy masked", 32'(nb), 32'd0);
      chk("R2 no writes", 32'(wr_cnt - w0), 32'd0);
      irq_pending = 1'b0;
      core_load(16'h1234, 8'h56, 8'h78, 8'h00);
      chk("R9 load pc", 32'(pc), 32'h1234);
      chk("R9 load cc", 32'(cc), 32'h00);
      boundary(1'b0, fg, nb);
      chk("R2 fetch_go idle", 32'(fg), 32'h1);
      chk("R2 sp kept", 32'(sp), 32'h00FF);
   endtask

   task automatic t_entry;
      logic fg; int nb; int a0;
      a0 = ack_cnt;
      irq_pending = 1'b1;
      fork
         boundary(1'b0, fg, nb);
         begin
            repeat (3) @(negedge clk);
            core_wr = 1'b1; core_pc = 16'hDEAD; core_x = 8'hEE; core_a = 8'hEE; core_cc = 8'h00;
            @(negedge clk);
            core_wr = 1'b0;
         end
      join
      irq_pending = 1'b0;
      chk("R2 no fetch on entry", 32'(fg), 32'h0);
      chk("R6 entry busy", 32'(nb), 32'd8);
      chk("R3 stack pcl", 32'(mem[8'hFF]), 32'h34);
      chk("R3 stack pch", 32'(mem[8'hFE]), 32'h12);
      chk("R3 stack x", 32'(mem[8'hFD]), 32'h56);
      chk("R3 stack a", 32'(mem[8'hFC]), 32'h78);
      chk("R4 stacked cc unmasked", 32'(mem[8'hFB]), 32'h00);
      chk("R3 sp after", 32'(sp), 32'h00FA);
      chk("R4 pc vector", 32'(pc), 32'hABCD);
      chk("R4 mask set", 32'(cc), 32'h08);
      chk("R5 ack once", 32'(ack_cnt - a0), 32'd1);
      chk("R5 ack with fetch", 32'(ack_bad), 32'd0);
      chk("R9 ignored while busy", 32'(x), 32'h56);
   endtask

   task automatic t_return;
      logic fg; int nb;
      boundary(1'b1, fg, nb);
      chk("R7 return busy", 32'(nb), 32'd6);
      chk("R7 pc", 32'(pc), 32'h1234);
      chk("R7 x", 32'(x), 32'h56);
      chk("R7 a", 32'(a), 32'h78);
      chk("R7 cc mask restored clear", 32'(cc), 32'h00);
      chk("R7 sp", 32'(sp), 32'h00FF);
   endtask

   task automatic t_tail;
      logic fg; int nb; int a0;
      irq_pending = 1'b1;
      boundary(1'b0, fg, nb);
      a0 = ack_cnt;
      boundary(1'b1, fg, nb);
      irq_pending = 1'b0;
      chk("R8 tail busy", 32'(nb), 32'd14);
      chk("R8 tail ack", 32'(ack_cnt - a0), 32'd1);
      chk("R8 tail pc", 32'(pc), 32'hABCD);
      chk("R8 tail sp", 32'(sp), 32'h00FA);
      chk("R8 tail restack pcl", 32'(mem[8'hFF]), 32'h34);
   endtask

   task automatic t_nested;
      logic fg; int nb;
      core_load(16'h2222, 8'h11, 8'h33, 8'h00);
      irq_pending = 1'b1;
      boundary(1'b0, fg, nb);
      irq_pending = 1'b0;
      chk("R3 nested sp", 32'(sp), 32'h00F5);
      chk("R3 nested stack a", 32'(mem[8'hF7]), 32'h33);
      boundary(1'b1, fg, nb);
      chk("R7 nested pc", 32'(pc), 32'h2222);
      chk("R7 nested sp", 32'(sp), 32'h00FA);
      chk("R8 fetch after return", 32'(fg), 32'h0);
   endtask

   task automatic t_saved_mask;
      logic fg; int nb; int a0;
      mem[8'hFB] = 8'h09;
      a0 = ack_cnt;
      irq_pending = 1'b1;
      boundary(1'b1, fg, nb);
      chk("R8 masked return busy", 32'(nb), 32'd6);
      chk("R7 cc saved mask", 32'(cc), 32'h09);
      chk("R8 no reentry", 32'(ack_cnt - a0), 32'd0);
      chk("R7 sp home", 32'(sp), 32'h00FF);
      irq_pending = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      mem[8'h40] = 8'hAB;
      mem[8'h41] = 8'hCD;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_masked;
      t_entry;
      t_return;
      t_tail;
      t_nested;
      t_saved_mask;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule